// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI bus master. Software reaches it through a small register port and can write one byte to send and read one received byte. One holding register sits in front of the shift register, so a second byte can wait while the first one shifts. When a byte finishes and another is waiting, the waiting byte starts on the very next SCK edge slot, and a run of bytes goes out with uniform edge spacing. The SCK period is fixed at `2*DIV_HALF` system clocks. All four clock polarity/phase combinations are supported. Data is sent MSB first.

Two flags follow the bytes as they move. The transmit-empty flag rises when the holding register hands its byte to the shifter. The receive-full flag rises when a finished byte lands in the receive register. Two error flags are also kept: overrun, and a bus fault reported on an input pin. Each interrupt output is the AND of a flag with its own enable. The error flags feed the receive/error interrupt through a separate enable.

The register port has no stall. Every access completes in the cycle it is presented. Back-pressure on the transmit side comes only from the transmit-empty flag: software may write a byte when that flag is high. A write made while the flag is low is dropped. On the receive side, a byte that completes while the previous byte is still unread is also dropped, and the overrun flag records the loss.

Top module: `spi_dbuf_master`

## Requirements
- R1: The register map is fixed as follows. Address 0 is control: bit0 enable, bit1 clock polarity, bit2 clock phase, bit3 transmit interrupt enable, bit4 receive interrupt enable, bit5 error interrupt enable; it reads back. Address 1 is status, read-only apart from write-1-to-clear bits: bit0 transmit empty, bit1 receive full, bit2 overrun, bit3 bus fault. Address 2 is data: a write queues a byte and a read returns the received byte.
- R2: A byte written while another byte is shifting is held. While it waits, transmit-empty reads 0. It is sent next.
- R3: A queued byte starts with no gap. N bytes sent back to back span exactly (16N-1)*DIV_HALF system clocks between the first and the last SCK edge.
- R4: Transmit-empty is 1 whenever the block is enabled and the holding register is empty. It rises when the held byte moves into the shifter and falls on an accepted data write.
- R5: Receive-full rises when a completed byte is copied into the receive register. A read of address 2 clears it.
- R6: `irq_tx` is high exactly when transmit-empty and the transmit interrupt enable are both 1.
- R7: `irq_rxerr` is high when receive-full and the receive interrupt enable are both 1.
- R8: `irq_rxerr` is also high when overrun or bus fault is set and the error interrupt enable is 1. A set receive-full flag alone does not assert it while the receive interrupt enable is 0.
- R9: All four polarity/phase modes transfer MSB first. SCK idles at the polarity level. With phase 0, data is sampled on the leading edge. With phase 1, data is sampled on the trailing edge. The phase 1 / polarity 0 case works back to back.
- R10: A data write while transmit-empty is 0 is ignored. The held byte is sent unchanged, and no extra byte follows it.
- R11: A byte that completes while receive-full is still set raises overrun. The unread byte is kept in the receive register.
- R12: A high level on `bus_fault` while enabled sets the bus-fault flag. Writing 1 to status bit2 clears overrun, and writing 1 to status bit3 clears bus fault.
- R13: While enable is 0, the shifter is idle, SCK sits at the polarity level, all four flags read 0, and data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 2 clears receive-full |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| bus_fault | input | 1 | Fault report from the bus; sets the bus-fault flag |
| irq_tx | output | 1 | Transmitter interrupt |
| irq_rxerr | output | 1 | Receiver/error interrupt |

## Verification
All four polarity/phase modes are each run with three bytes back to back. A bench slave samples and launches on the edges that R9 assigns to each mode, so a wrong sampling edge or bit order shows up as a corrupted byte. The measured first-to-last SCK span separates a true back-to-back restart from one that inserts an idle slot.

The flag tests cover several cases:
- Two writes on consecutive cycles separate a dropped write from a corrupting one.
- Leaving a byte unread across a second transfer separates keeping the old byte from overwriting it.
- Toggling each interrupt enable on its own separates the receive path from the error path.

A disable/re-enable sequence shows that flags clear and that writes made while disabled leave no trace on the bus.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int CTRL_W = 6;
  localparam int STAT_W = 4;

  // Packed so that en lands on bit 0 and err_ie on bit 5.
  typedef struct packed {
    logic err_ie;
    logic rx_ie;
    logic tx_ie;
    logic cpha;
    logic cpol;
    logic en;
  } ctrl_t;

  localparam int ST_TXE  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_FLT  = 3;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DIV_HALF) + 1;
  localparam logic [CW-1:0] TOP = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= TOP;
    else if (!run)       cnt_q <= TOP;
    else if (cnt_q == '0) cnt_q <= TOP;
    else                 cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpha,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              last_edge,
  output logic              phase,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0]     ecnt_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic              busy_q, phase_q, mosi_q;
  logic              edge_now, launch, sample;

  assign edge_now  = en && busy_q && tick;
  assign last_edge = edge_now && (ecnt_q == LAST);
  // Phase 1 launches on even edges; phase 0 launches on odd edges, bar the final one.
  assign launch = cpha ? !ecnt_q[0] : (ecnt_q[0] && (ecnt_q != LAST));
  assign sample = cpha ?  ecnt_q[0] : !ecnt_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      mosi_q  <= 1'b0;
      ecnt_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (!en) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
      if (cpha) begin
        tx_sh_q <= load_data;
      end else begin
        mosi_q  <= load_data[DATA_W-1];
        tx_sh_q <= load_data << 1;
      end
    end else if (edge_now) begin
      phase_q <= !phase_q;
      ecnt_q  <= ecnt_q + 1'b1;
      if (ecnt_q == LAST) busy_q <= 1'b0;
      if (launch) begin
        mosi_q  <= tx_sh_q[DATA_W-1];
        tx_sh_q <= tx_sh_q << 1;
      end
      if (sample) rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
    end
  end

  // With phase 1 the final sample falls on the final edge itself.
  assign rx_byte = cpha ? {rx_sh_q[DATA_W-2:0], miso} : rx_sh_q;
  assign busy    = busy_q;
  assign phase   = phase_q;
  assign mosi    = mosi_q;
endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate (
  input  logic tx_empty,
  input  logic rx_full,
  input  logic ovr,
  input  logic fault,
  input  logic tx_ie,
  input  logic rx_ie,
  input  logic err_ie,
  output logic irq_tx,
  output logic irq_rxerr
);
  assign irq_tx    = tx_empty && tx_ie;
  assign irq_rxerr = (rx_full && rx_ie) || ((ovr || fault) && err_ie);
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              bus_fault,
  output logic              irq_tx,
  output logic              irq_rxerr
);
  ctrl_t             ctl_q;
  logic [DATA_W-1:0] hold_q, rx_q, rx_byte;
  logic              hold_full, rx_full, ovr, flt;
  logic              busy, last_edge, phase, tick;
  logic              tx_empty, tx_load;
  logic              wr_ctl, wr_stat, wr_data, rd_data;

  assign wr_ctl   = wr_en && (addr == A_CTRL);
  assign wr_stat  = wr_en && (addr == A_STAT);
  assign wr_data  = wr_en && (addr == A_DATA);
  assign rd_data  = rd_en && (addr == A_DATA);
  assign tx_empty = ctl_q.en && !hold_full;
  assign tx_load  = ctl_q.en && hold_full && (!busy || last_edge);

  spi_half_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .cpha(ctl_q.cpha),
    .load(tx_load), .load_data(hold_q), .tick(tick), .miso(miso),
    .busy(busy), .last_edge(last_edge), .phase(phase), .mosi(mosi),
    .rx_byte(rx_byte)
  );

  spi_irq_gate u_irq (
    .tx_empty(tx_empty), .rx_full(rx_full), .ovr(ovr), .fault(flt),
    .tx_ie(ctl_q.tx_ie), .rx_ie(ctl_q.rx_ie), .err_ie(ctl_q.err_ie),
    .irq_tx(irq_tx), .irq_rxerr(irq_rxerr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  // Transmit holding register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (!ctl_q.en) begin
      hold_full <= 1'b0;
    end else begin
      if (tx_load) hold_full <= 1'b0;
      if (wr_data && tx_empty) begin
        hold_q    <= wdata;
        hold_full <= 1'b1;
      end
    end
  end

  // Receive register and error flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      flt     <= 1'b0;
    end else if (!ctl_q.en) begin
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      flt     <= 1'b0;
    end else begin
      if (last_edge) begin
        if (rx_full && !rd_data) begin
          ovr <= 1'b1;
        end else begin
          rx_q    <= rx_byte;
          rx_full <= 1'b1;
        end
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
      if (wr_stat && wdata[ST_OVR] && !(last_edge && rx_full && !rd_data)) ovr <= 1'b0;
      if (bus_fault)                        flt <= 1'b1;
      else if (wr_stat && wdata[ST_FLT])    flt <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctl_q;
      A_STAT:  rdata[STAT_W-1:0] = {flt, ovr, rx_full, tx_empty};
      A_DATA:  rdata = rx_q;
      default: rdata = '0;
    endcase
  end

  assign sck = phase ^ ctl_q.cpol;
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cpol,
  input logic              tx_ie,
  input logic              sck,
  input logic              wr_data,
  input logic              rd_data,
  input logic              tx_empty,
  input logic              tx_load,
  input logic              hold_full,
  input logic [DATA_W-1:0] hold_q,
  input logic              last_edge,
  input logic              busy,
  input logic              rx_full,
  input logic [DATA_W-1:0] rx_q,
  input logic              irq_tx
);
  a_r13_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (sck == cpol));

  a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tx_empty) |=> $stable(hold_q));

  a_r4_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_empty || !en));

  a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && hold_full) |=> (busy || !en));

  a_r5_rx_lands: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> (rx_full || !en));

  a_r11_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && rx_full && !rd_data) |=> $stable(rx_q));

  a_r6_irq_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> (tx_ie && !hold_full));
endmodule

bind spi_dbuf_master spi_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .cpol(ctl_q.cpol),
  .tx_ie(ctl_q.tx_ie), .sck(sck), .wr_data(wr_data), .rd_data(rd_data),
  .tx_empty(tx_empty), .tx_load(tx_load), .hold_full(hold_full),
  .hold_q(hold_q), .last_edge(last_edge), .busy(busy), .rx_full(rx_full),
  .rx_q(rx_q), .irq_tx(irq_tx)
);

// File: tb/tb_spi_dbuf_master.sv
`timescale 1ns/1ps
module tb_spi_dbuf_master;
  localparam int DW = 8;
  localparam int DH = 2;
  localparam int TCK = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, bus_fault = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic sck, mosi, miso, irq_tx, irq_rxerr;

  int total = 0, bad = 0;

  spi_dbuf_master #(.DATA_W(DW), .DIV_HALF(DH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .bus_fault(bus_fault), .irq_tx(irq_tx), .irq_rxerr(irq_rxerr)
  );

  always #(TCK/2) clk = !clk;

  // Bench slave model
  logic       tb_cpol = 1'b0, tb_cpha = 1'b0, slv_on = 1'b0, slv_rst = 1'b0;
  logic [7:0] slv_tx [8];
  logic [7:0] got [8];
  logic [7:0] cap = '0;
  logic       slv_bit = 1'b0;
  int         k = 0, si = 0, gi = 0, ecount = 0;
  time        t_first = 0, t_last = 0;

  assign miso = slv_bit;

  always @(posedge sck or negedge sck or posedge slv_rst) begin
    if (slv_rst) begin
      k = 0; si = 0; gi = 0; ecount = 0;
      slv_bit = slv_tx[0][7];
    end else if (slv_on) begin
      ecount++;
      if (ecount == 1) t_first = $time;
      t_last = $time;
      if ((sck != tb_cpol) ^ tb_cpha) begin
        cap = {cap[6:0], mosi};
        k++;
        if (k == 8) begin
          got[gi % 8] = cap;
          gi++;
          k = 0;
          si++;
        end
      end else begin
        slv_bit = slv_tx[si % 8][7-k];
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr2(input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    @(negedge clk); addr = 2'd2; wdata = d0; wr_en = 1'b1;
    @(negedge clk); wdata = d1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_stat(input logic [DW-1:0] mask, input string tag);
    logic [DW-1:0] s;
    for (int n = 0; n < 400; n++) begin
      rd(2'd1, s);
      if ((s & mask) != 0) return;
    end
    chk({tag, " wait timeout"}, 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slv_start(input logic cp, input logic ch);
    tb_cpol = cp; tb_cpha = ch;
    slv_rst = 1'b1; #1 slv_rst = 1'b0;
    slv_on = 1'b1;
  endtask

  initial begin
    #(200000 * TCK);
    chk("watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [7:0] b [3];
    int gi_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R13 reset state
    rd(2'd0, v); chk("R1 ctrl after reset", v, 0);
    rd(2'd1, v); chk("R13 status after reset", v, 0);
    chk("R13 sck idle after reset", sck, 0);
    chk("R6 irq_tx after reset", irq_tx, 0);
    chk("R7 irq_rxerr after reset", irq_rxerr, 0);

    // R9 R3 R2: sweep of all four modes, three bytes back to back
    for (int m = 0; m < 4; m++) begin
      logic cp, ch;
      cp = m[1]; ch = m[0];
      for (int i = 0; i < 3; i++) begin
        b[i] = 8'((m * 53 + i * 29 + 150) & 255);
        slv_tx[i] = 8'((m * 71 + i * 113 + 60) & 255);
      end
      slv_on = 1'b0;
      wr(2'd0, {2'b00, 1'b0, 1'b0, 1'b1, ch, cp, 1'b0});
      idle(2);
      chk($sformatf("R13 sck idles at polarity m%0d", m), sck, cp);
      slv_start(cp, ch);
      wr(2'd0, {2'b00, 1'b0, 1'b0, 1'b1, ch, cp, 1'b1});
      rd(2'd0, v); chk($sformatf("R1 ctrl readback m%0d", m), v, {2'b00, 3'b001, ch, cp, 1'b1});
      rd(2'd1, v); chk($sformatf("R4 empty on enable m%0d", m), v, 1);
      wr(2'd2, b[0]);
      wait_stat(8'h01, "R4 load");
      wr(2'd2, b[1]);
      rd(2'd1, v); chk($sformatf("R2 held byte clears empty m%0d", m), v[0], 0);
      chk($sformatf("R6 irq_tx low while held m%0d", m), irq_tx, 0);
      wait_stat(8'h02, "R5 rx0");
      rd(2'd2, v); chk($sformatf("R9 rx byte0 m%0d", m), v, slv_tx[0]);
      rd(2'd1, v); chk($sformatf("R5 read clears full m%0d", m), v[1], 0);
      wait_stat(8'h01, "R4 load1");
      chk($sformatf("R6 irq_tx on empty m%0d", m), irq_tx, 1);
      wr(2'd2, b[2]);
      wait_stat(8'h02, "R5 rx1");
      rd(2'd2, v); chk($sformatf("R9 rx byte1 m%0d", m), v, slv_tx[1]);
      wait_stat(8'h02, "R5 rx2");
      rd(2'd2, v); chk($sformatf("R9 rx byte2 m%0d", m), v, slv_tx[2]);
      idle(20);
      chk($sformatf("R9 mosi bytes m%0d", m), {got[0], got[1], got[2]}, {b[0], b[1], b[2]});
      chk($sformatf("R3 edge count m%0d", m), ecount, 48);
      chk($sformatf("R3 span ns m%0d", m), int'(t_last - t_first), (16 * 3 - 1) * DH * TCK);
    end

    // R10: a second write on the next cycle is dropped
    slv_on = 1'b0;
    wr(2'd0, 8'h08);
    for (int i = 0; i < 8; i++) slv_tx[i] = 8'((i * 37 + 11) & 255);
    slv_start(1'b0, 1'b0);
    wr(2'd0, 8'h09);
    chk("R6 irq_tx with enable", irq_tx, 1);
    wr2(8'hC3, 8'h5E);
    wait_stat(8'h02, "R10 rx");
    rd(2'd2, v);
    idle(60);
    chk("R10 only one byte sent", gi, 1);
    chk("R10 held byte intact", got[0], 8'hC3);
    rd(2'd1, v); chk("R10 status after drop", v, 1);

    // R11 R8 R12: overrun and error interrupt
    slv_on = 1'b0;
    wr(2'd0, 8'h20);
    slv_start(1'b0, 1'b0);
    wr(2'd0, 8'h21);
    wr(2'd2, 8'h11);
    wait_stat(8'h02, "R11 first");
    chk("R8 rx_full alone gated off", irq_rxerr, 0);
    wr(2'd2, 8'h22);
    wait_stat(8'h04, "R11 ovr");
    rd(2'd1, v); chk("R11 status on overrun", v, 8'h07);
    chk("R8 irq_rxerr on overrun", irq_rxerr, 1);
    rd(2'd2, v); chk("R11 unread byte kept", v, slv_tx[0]);
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk("R12 overrun cleared", v, 8'h01);
    chk("R8 irq_rxerr after clear", irq_rxerr, 0);

    // R7: receive interrupt
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h33);
    wait_stat(8'h02, "R7 rx");
    chk("R7 irq_rxerr on rx_full", irq_rxerr, 1);
    rd(2'd2, v); chk("R7 rx data", v, slv_tx[2]);
    chk("R5 irq drops after read", irq_rxerr, 0);

    // R12 bus fault
    wr(2'd0, 8'h21);
    @(negedge clk); bus_fault = 1'b1;
    @(negedge clk); bus_fault = 1'b0;
    rd(2'd1, v); chk("R12 fault flag set", v, 8'h09);
    chk("R8 irq_rxerr on fault", irq_rxerr, 1);
    wr(2'd1, 8'h08);
    rd(2'd1, v); chk("R12 fault flag cleared", v, 8'h01);

    // R13 disable clears flags and ignores writes
    wr(2'd2, 8'h44);
    wait_stat(8'h02, "R13 rx");
    @(negedge clk); bus_fault = 1'b1;
    @(negedge clk); bus_fault = 1'b0;
    rd(2'd1, v); chk("R13 flags before disable", v, 8'h0B);
    wr(2'd0, 8'h20);
    rd(2'd1, v); chk("R13 flags clear when disabled", v, 0);
    chk("R13 irq low when disabled", irq_rxerr, 0);
    gi_before = gi;
    wr(2'd2, 8'h77);
    idle(4);
    wr(2'd0, 8'h21);
    rd(2'd1, v); chk("R13 write while disabled ignored", v, 8'h01);
    idle(60);
    chk("R13 no transfer after re-enable", gi, gi_before);
    chk("R13 sck idle", sck, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule